// File: doc/BRIEF.md
# Eight-Source Interrupt Controller With Hold Wake

This block gathers interrupt events for a small 4-bit microcontroller core and turns them into a single request with a 3-bit vector index. Eight event slots exist. They are a divider overflow, two timer underflows, a change on either of two input ports, and the end of speech or melody playback. A playback end is seen as the falling edge of that engine's busy line. Slot 4 is reserved. Each slot has a sticky event flag and an enable bit. A global enable bit gates the whole controller.

The core accepts a request by pulsing an acknowledge. Acceptance clears only the flag of the chosen slot. It then blocks further requests until software writes either half of the enable register or performs a global-enable operation. Simple strobes stand in for the core's enable-register and mode-register instructions.

A small hold sequencer tracks the core's low-power hold state. A request that arrives during hold releases hold for the service routine. The return strobe at the end of that routine puts the core back into hold.

Top module: `irq_hold_ctrl`

## Requirements
- R1: After reset, en_rdata_o is 0x00, mode_rdata_o is 4'b0001, flag_o is 0x00, irq_o is 0 and hold_o is 0.
- R2: en_we_i[0] loads enable bits 3:0 from en_wdata_i[3:0]. en_we_i[1] loads enable bits 7:4 from en_wdata_i[7:4]. Both strobes together load all 8 bits. en_rdata_o returns the stored value, including bit 4.
- R3: The flag bits map to sources as follows. Bit 0 is div_ovf_i. Bit 1 is tmr0_unf_i. Bit 7 is tmr1_unf_i. Bit 5 is a falling edge of spk_busy_i. Bit 6 is a falling edge of mel_busy_i. Each of these shows on flag_o after the first clock edge that sees the event. A rising busy edge sets nothing.
- R4: Bit 2 is set by any change on port_c_i and bit 3 by any change on port_d_i. Each port passes through a two-stage synchronizer, so the flag shows after the third clock edge following the change and not after the second.
- R5: A flag is set whatever its enable bit holds. It is cleared only by acceptance of its own interrupt or by reset. If a new event arrives in the same cycle its flag is cleared, the flag stays set.
- R6: irq_o is 1 exactly when the global enable is 1, the controller is not blocked, and some flag has its enable bit set. vec_o gives the lowest-numbered such bit.
- R7: Acceptance is irq_ack_i high while irq_o is 1. It clears only flag_o[vec_o], and an irq_ack_i without a request has no effect.
- R8: After acceptance, irq_o stays 0 until one of these unblocks it: an enable write on either half, gie_set_i, or mode_we_i with mode_wdata_i[0]=1.
- R9: mode_rdata_o[0] is the global enable and bits 3:1 read 0. gie_clr_i clears the enable. gie_set_i sets it. mode_we_i loads it from mode_wdata_i[0]. Priority runs clear, then set, then write.
- R10: Reserved bit 4 never raises irq_o, whatever is written to enable bit 4.
- R11: hold_req_i rises hold_o at the next edge. While hold_o is 1, a pending irq_o drops hold_o at the next edge. After that, rtn_i raises hold_o again at the next edge. rtn_i has no effect when no hold-wake service is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_ovf_i | input | 1 | Divider overflow pulse |
| tmr0_unf_i | input | 1 | Timer 0 underflow pulse |
| tmr1_unf_i | input | 1 | Timer 1 underflow pulse |
| port_c_i | input | PORT_W | First watched input port (asynchronous) |
| port_d_i | input | PORT_W | Second watched input port (asynchronous) |
| spk_busy_i | input | 1 | Speech engine busy |
| mel_busy_i | input | 1 | Melody engine busy |
| en_we_i | input | 2 | Enable register nibble write strobes |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register read data |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 4 | Mode register write data |
| mode_rdata_o | output | 4 | Mode register read data |
| gie_set_i | input | 1 | Global-enable operation |
| gie_clr_i | input | 1 | Global-disable operation |
| flag_o | output | 8 | Event flags |
| irq_o | output | 1 | Interrupt request to core |
| vec_o | output | 3 | Index of the granted source |
| irq_ack_i | input | 1 | Core accepts the request |
| hold_req_i | input | 1 | Core enters hold |
| rtn_i | input | 1 | Return from service routine |
| hold_o | output | 1 | Core held |

## Verification
The bench aims an acknowledge at a cycle in which the same source fires again. A design that lets the clear win would lose that event. It checks each port flag one edge early. A design with a missing synchronizer stage, or a spare one, sets the flag one edge off. Each busy line is raised and then dropped. A design that detects the wrong edge flags playback start instead of playback end. Requests after acceptance are tried against each unblocking path, and the set and clear operations are applied in the same cycle. A controller that forgets the block, or that ranks the operations wrongly, keeps raising requests. Hold is tested with a stray return before any wake. A wrong sequencer leaves hold early or never goes back into it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 8;
  localparam int VEC_W  = $clog2(NSRC);
  localparam int NIB    = NSRC / 4;
  localparam int MODE_W = 4;

  localparam int SRC_DIV  = 0;
  localparam int SRC_TM0  = 1;
  localparam int SRC_PC   = 2;
  localparam int SRC_PD   = 3;
  localparam int SRC_RSV  = 4;
  localparam int SRC_SPK  = 5;
  localparam int SRC_MEL  = 6;
  localparam int SRC_TM1  = 7;

  localparam logic [NSRC-1:0] RSV_MASK = NSRC'(1) << SRC_RSV;

  typedef enum logic [1:0] {HS_RUN, HS_HOLD, HS_SVC} hold_st_e;
endpackage

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] port_i,
  output logic         chg_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= port_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign chg_o = |(stg_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect import irq_pkg::*; #(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_ovf_i,
  input  logic              tmr0_unf_i,
  input  logic              tmr1_unf_i,
  input  logic [PORT_W-1:0] port_c_i,
  input  logic [PORT_W-1:0] port_d_i,
  input  logic              spk_busy_i,
  input  logic              mel_busy_i,
  output logic [NSRC-1:0]   evt_o
);
  localparam int NBUSY = 2;
  localparam int NPORT = 2;

  logic [PORT_W-1:0] port_in [NPORT];
  logic [NPORT-1:0]  port_chg;
  logic [NBUSY-1:0]  busy, busy_q, busy_fall;

  assign port_in[0] = port_c_i;
  assign port_in[1] = port_d_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    irq_port_watch #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_watch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .port_i (port_in[p]),
      .chg_o  (port_chg[p])
    );
  end

  assign busy = {mel_busy_i, spk_busy_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy;
  end

  assign busy_fall = busy_q & ~busy;

  always_comb begin
    evt_o          = '0;
    evt_o[SRC_DIV] = div_ovf_i;
    evt_o[SRC_TM0] = tmr0_unf_i;
    evt_o[SRC_PC]  = port_chg[0];
    evt_o[SRC_PD]  = port_chg[1];
    evt_o[SRC_SPK] = busy_fall[0];
    evt_o[SRC_MEL] = busy_fall[1];
    evt_o[SRC_TM1] = tmr1_unf_i;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_hold_seq.sv
module irq_hold_seq import irq_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_req_i,
  input  logic irq_i,
  input  logic rtn_i,
  output logic hold_o
);
  hold_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_RUN:  if (hold_req_i) st_d = HS_HOLD;
      HS_HOLD: if (irq_i)      st_d = HS_SVC;
      HS_SVC:  if (rtn_i)      st_d = HS_HOLD;
      default:                 st_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= HS_RUN;
    else         st_q <= st_d;
  end

  assign hold_o = (st_q == HS_HOLD);
endmodule

// File: rtl/irq_hold_ctrl.sv
module irq_hold_ctrl import irq_pkg::*; #(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_ovf_i,
  input  logic              tmr0_unf_i,
  input  logic              tmr1_unf_i,
  input  logic [PORT_W-1:0] port_c_i,
  input  logic [PORT_W-1:0] port_d_i,
  input  logic              spk_busy_i,
  input  logic              mel_busy_i,
  input  logic [NIB-1:0]    en_we_i,
  input  logic [NSRC-1:0]   en_wdata_i,
  output logic [NSRC-1:0]   en_rdata_o,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output logic [MODE_W-1:0] mode_rdata_o,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  output logic [NSRC-1:0]   flag_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  input  logic              irq_ack_i,
  input  logic              hold_req_i,
  input  logic              rtn_i,
  output logic              hold_o
);
  logic [NSRC-1:0]  evt, flag_q, en_q, req, clr;
  logic             gie_q, blk_q, any_req, accept, unblock;
  logic [VEC_W-1:0] vec;

  irq_src_detect #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_ovf_i  (div_ovf_i),
    .tmr0_unf_i (tmr0_unf_i),
    .tmr1_unf_i (tmr1_unf_i),
    .port_c_i   (port_c_i),
    .port_d_i   (port_d_i),
    .spk_busy_i (spk_busy_i),
    .mel_busy_i (mel_busy_i),
    .evt_o      (evt)
  );

  // enable register, written per nibble
  for (genvar g = 0; g < NIB; g++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       en_q[g*4 +: 4] <= '0;
      else if (en_we_i[g]) en_q[g*4 +: 4] <= en_wdata_i[g*4 +: 4];
    end
  end

  assign accept  = irq_o & irq_ack_i;
  assign unblock = (|en_we_i) | gie_set_i | (mode_we_i & mode_wdata_i[0]);

  always_comb begin
    clr = '0;
    if (accept) clr[vec] = 1'b1;
  end

  // new event beats same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr) | (evt & ~RSV_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gie_q <= 1'b1;
    else if (gie_clr_i) gie_q <= 1'b0;
    else if (gie_set_i) gie_q <= 1'b1;
    else if (mode_we_i) gie_q <= mode_wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      blk_q <= 1'b0;
    else if (accept)  blk_q <= 1'b1;
    else if (unblock) blk_q <= 1'b0;
  end

  assign req = flag_q & en_q & ~RSV_MASK;

  irq_prio_enc #(.N(NSRC)) u_prio (
    .req_i (req),
    .any_o (any_req),
    .idx_o (vec)
  );

  irq_hold_seq u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_req_i (hold_req_i),
    .irq_i      (irq_o),
    .rtn_i      (rtn_i),
    .hold_o     (hold_o)
  );

  assign irq_o        = gie_q & ~blk_q & any_req;
  assign vec_o        = vec;
  assign flag_o       = flag_q;
  assign en_rdata_o   = en_q;
  assign mode_rdata_o = {{(MODE_W-1){1'b0}}, gie_q};
endmodule

// File: rtl/irq_hold_ctrl_chk.sv
module irq_hold_ctrl_chk import irq_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              irq_ack_i,
  input logic [VEC_W-1:0]  vec_o,
  input logic [NSRC-1:0]   flag_o,
  input logic [NSRC-1:0]   evt,
  input logic [NIB-1:0]    en_we_i,
  input logic              gie_set_i,
  input logic              mode_we_i,
  input logic [MODE_W-1:0] mode_wdata_i,
  input logic [MODE_W-1:0] mode_rdata_o,
  input logic              hold_o
);
  logic acc;
  assign acc = irq_o && irq_ack_i;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> ((flag_o & $past(flag_o)) == $past(flag_o))); // R5

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mode_rdata_o[0]); // R6

  AST_ACK_CLEARS_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !evt[vec_o]) |=> !flag_o[$past(vec_o)]); // R7

  AST_ACK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !(|en_we_i) && !gie_set_i && !(mode_we_i && mode_wdata_i[0])) |=> !irq_o); // R8

  AST_RSV_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o != VEC_W'(SRC_RSV))); // R10

  AST_HOLD_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && irq_o) |=> !hold_o); // R11
endmodule

bind irq_hold_ctrl irq_hold_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_o        (irq_o),
  .irq_ack_i    (irq_ack_i),
  .vec_o        (vec_o),
  .flag_o       (flag_o),
  .evt          (evt),
  .en_we_i      (en_we_i),
  .gie_set_i    (gie_set_i),
  .mode_we_i    (mode_we_i),
  .mode_wdata_i (mode_wdata_i),
  .mode_rdata_o (mode_rdata_o),
  .hold_o       (hold_o)
);

// File: tb/irq_hold_ctrl_test.sv
module irq_hold_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_ovf = 0, tmr0_unf = 0, tmr1_unf = 0;
  logic [3:0] port_c = '0, port_d = '0;
  logic       spk_busy = 0, mel_busy = 0;
  logic [1:0] en_we = '0;
  logic [7:0] en_wdata = '0, en_rdata;
  logic       mode_we = 0;
  logic [3:0] mode_wdata = '0, mode_rdata;
  logic       gie_set = 0, gie_clr = 0;
  logic [7:0] flag;
  logic       irq;
  logic [2:0] vec;
  logic       irq_ack = 0, hold_req = 0, rtn = 0, hold;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_hold_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .div_ovf_i(div_ovf), .tmr0_unf_i(tmr0_unf), .tmr1_unf_i(tmr1_unf),
    .port_c_i(port_c), .port_d_i(port_d),
    .spk_busy_i(spk_busy), .mel_busy_i(mel_busy),
    .en_we_i(en_we), .en_wdata_i(en_wdata), .en_rdata_o(en_rdata),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wdata), .mode_rdata_o(mode_rdata),
    .gie_set_i(gie_set), .gie_clr_i(gie_clr),
    .flag_o(flag), .irq_o(irq), .vec_o(vec), .irq_ack_i(irq_ack),
    .hold_req_i(hold_req), .rtn_i(rtn), .hold_o(hold)
  );

  // {en_we, en_wdata, {tmr1,tmr0,div}, ack, exp_flag, exp_irq, exp_vec}
  localparam int NV = 12;
  localparam logic [25:0] TBL [NV] = '{
    {2'b00, 8'h00, 3'b001, 1'b0, 8'h01, 1'b0, 3'd0},  // R5 latch while disabled
    {2'b01, 8'h03, 3'b000, 1'b0, 8'h01, 1'b1, 3'd0},  // R6
    {2'b00, 8'h00, 3'b010, 1'b0, 8'h03, 1'b1, 3'd0},  // R6 lowest first
    {2'b00, 8'h00, 3'b000, 1'b1, 8'h02, 1'b0, 3'd0},  // R7 R8
    {2'b00, 8'h00, 3'b100, 1'b0, 8'h82, 1'b0, 3'd0},  // R8 still blocked
    {2'b10, 8'h80, 3'b000, 1'b0, 8'h82, 1'b1, 3'd1},  // R8 high write unblocks
    {2'b00, 8'h00, 3'b000, 1'b1, 8'h80, 1'b0, 3'd0},  // R7
    {2'b01, 8'h00, 3'b000, 1'b0, 8'h80, 1'b1, 3'd7},  // R8 low write unblocks
    {2'b00, 8'h00, 3'b100, 1'b1, 8'h80, 1'b0, 3'd0},  // R5 event beats clear
    {2'b11, 8'h10, 3'b000, 1'b0, 8'h80, 1'b0, 3'd0},  // R10 reserved only
    {2'b11, 8'hFF, 3'b000, 1'b0, 8'h80, 1'b1, 3'd7},  // R10 skip bit4
    {2'b00, 8'h00, 3'b000, 1'b1, 8'h00, 1'b0, 3'd0}   // R7
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    div_ovf = 0; tmr0_unf = 0; tmr1_unf = 0; en_we = '0; mode_we = 0;
    gie_set = 0; gie_clr = 0; irq_ack = 0; hold_req = 0; rtn = 0;
  endtask

  task automatic do_reset();
    idle();
    port_c = '0; port_d = '0; spk_busy = 0; mel_busy = 0;
    rst_n = 0;
    tick();
    tick();
    rst_n = 1;
    tick();
  endtask

  task automatic wr_en(input logic [1:0] we, input logic [7:0] d);
    en_we = we; en_wdata = d;
    tick();
    en_we = '0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1;
    tick();
    irq_ack = 0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 en", en_rdata, 8'h00);
    chk("R1 mode", {4'h0, mode_rdata}, 8'h01);
    chk("R1 flag", flag, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 hold", {7'b0, hold}, 8'h00);

    // R2 nibble writes
    wr_en(2'b11, 8'h5A); chk("R2 full", en_rdata, 8'h5A);
    wr_en(2'b01, 8'hC3); chk("R2 low", en_rdata, 8'h53);
    wr_en(2'b10, 8'hF0); chk("R2 high", en_rdata, 8'hF3);

    // vector table
    do_reset();
    for (int i = 0; i < NV; i++) begin
      en_we = TBL[i][25:24];
      en_wdata = TBL[i][23:16];
      {tmr1_unf, tmr0_unf, div_ovf} = TBL[i][15:13];
      irq_ack = TBL[i][12];
      tick();
      idle();
      chk($sformatf("R5 step%0d flag", i), flag, TBL[i][11:4]);
      chk($sformatf("R6 step%0d irq", i), {7'b0, irq}, {7'b0, TBL[i][3]});
      if (TBL[i][3]) chk($sformatf("R6 step%0d vec", i), {5'b0, vec}, {5'b0, TBL[i][2:0]});
    end

    // R4 port change through synchronizer
    do_reset();
    port_c = 4'h5;
    tick(); tick();
    chk("R4 portc early", flag, 8'h00);
    tick();
    chk("R4 portc", flag, 8'h04);
    port_d = 4'h8;
    tick(); tick();
    chk("R4 portd early", flag, 8'h04);
    tick();
    chk("R4 portd", flag, 8'h0C);

    // R3 busy edges
    spk_busy = 1; tick();
    chk("R3 spk rise", flag, 8'h0C);
    spk_busy = 0; tick();
    chk("R3 spk fall", flag, 8'h2C);
    mel_busy = 1; tick();
    chk("R3 mel rise", flag, 8'h2C);
    mel_busy = 0; tick();
    chk("R3 mel fall", flag, 8'h6C);

    // R6 priority across these flags
    wr_en(2'b11, 8'hFF);
    chk("R6 vec2", {4'b0, irq, vec}, 8'h0A);
    pulse_ack();
    chk("R7 clear bit2", flag, 8'h68);
    wr_en(2'b11, 8'hFF);
    chk("R6 vec3", {4'b0, irq, vec}, 8'h0B);

    // R9 global enable
    do_reset();
    wr_en(2'b01, 8'h01);
    div_ovf = 1; tick(); idle();
    chk("R9 irq on", {7'b0, irq}, 8'h01);
    gie_clr = 1; tick(); idle();
    chk("R9 clr mode", {4'h0, mode_rdata}, 8'h00);
    chk("R9 clr irq", {7'b0, irq}, 8'h00);
    pulse_ack();
    chk("R7 ack ignored", flag, 8'h01);
    mode_we = 1; mode_wdata = 4'hF; tick(); idle();
    chk("R9 write mode", {4'h0, mode_rdata}, 8'h01);
    chk("R9 irq back", {7'b0, irq}, 8'h01);
    pulse_ack();
    div_ovf = 1; tick(); idle();
    chk("R8 blocked", {7'b0, irq}, 8'h00);
    gie_set = 1; tick(); idle();
    chk("R8 gie set unblocks", {7'b0, irq}, 8'h01);
    gie_set = 1; gie_clr = 1; tick(); idle();
    chk("R9 clr wins", {4'h0, mode_rdata}, 8'h00);

    // R11 hold wake
    do_reset();
    wr_en(2'b01, 8'h01);
    rtn = 1; tick(); idle();
    chk("R11 rtn in run", {7'b0, hold}, 8'h00);
    hold_req = 1; tick(); idle();
    chk("R11 enter hold", {7'b0, hold}, 8'h01);
    rtn = 1; tick(); idle();
    chk("R11 stray rtn", {7'b0, hold}, 8'h01);
    div_ovf = 1; tick(); idle();
    chk("R11 still held", {6'b0, hold, irq}, 8'h03);
    tick();
    chk("R11 woken", {7'b0, hold}, 8'h00);
    pulse_ack();
    chk("R11 service", {6'b0, hold, irq}, 8'h00);
    rtn = 1; tick(); idle();
    chk("R11 rehold", {7'b0, hold}, 8'h01);

    done = 1;
    summary();
  end
endmodule